// File: doc/BRIEF.md
# Iterative Square Root and Reciprocal Square Root Unit

This block takes one normalized unsigned fixed-point operand and returns both its square root and its reciprocal square root. A small computed seed table, addressed by the top operand bits, gives a coarse estimate of the reciprocal root. A fixed number of refinement rounds then tightens two coupled quantities: a root estimate and half of the reciprocal root. Each round is built only from multiply-add steps. A shared residual is formed first, then both quantities are corrected from it side by side. The unit has no divider.

A caller presents the operand together with a one-cycle start strobe. The unit is busy until it raises a one-cycle done strobe, and it ignores further strobes while it works. Both results then stay on the outputs until the next operation finishes. Exponent handling, rounding modes and special values are left to the surrounding logic.

Top module: `gs_sqrt_unit`

## Requirements
- R1: While reset is asserted and after it is released, done_o is 0 and both result outputs are 0 until the first operation finishes.
- R2: For an operand code v with 2^22 <= v < 2^24, read as v/2^22 in [1,4), sqrt_o is read as sqrt_o/2^22 and differs from floor(sqrt(v*2^22)) by at most 4 codes.
- R3: For the same operand, rsqrt_o is read as rsqrt_o/2^22 and differs from floor(sqrt(2^66/v)) by at most 4 codes.
- R4: With the default of 2 refinement rounds, done_o is high for exactly one cycle. It rises on the rising edge that comes 2*ITERS+2 edges after the edge that samples start_i, and it is low in every cycle between those two edges.
- R5: A start_i strobe, or a change of value_i, while an operation is in progress has no effect. The result belongs to the operand captured at the start, the timing is unchanged, and no extra done_o follows.
- R6: Between operations, sqrt_o and rsqrt_o hold their last results even while value_i changes and start_i stays low.
- R7: The seed table has 128 entries. Operands below 2 use the 6 fraction bits just below the binary point. Operands of 2 or more use the lower integer bit and the 5 fraction bits below it. R2 and R3 hold at the first and last operand code of every one of those 128 segments.
- R8: A new start_i in the cycle right after done_o is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request; takes effect only when idle |
| value_i | input | IN_W (24) | Operand, 2 integer and 22 fraction bits, in [1,4) |
| done_o | output | 1 | One-cycle strobe marking fresh results |
| sqrt_o | output | IN_W (24) | Square root, 2 integer and 22 fraction bits |
| rsqrt_o | output | IN_W (24) | Reciprocal square root, 2 integer and 22 fraction bits |

## Verification
The operand space is covered by a strided sweep from 1 to just below 4, and by the first and last code of every seed segment. The segment codes are where the seed is furthest from the true value, so they separate a wrong table or a wrong index from a merely coarse one. The bench also starts operations back to back, injects a stray strobe with a different operand in the middle of a run, and changes the operand between runs. These cases separate correct operand capture and output holding from logic that follows value_i live. Exact done timing is checked on every operation, so a missing or extra refinement round shows up even where the results would still fall inside the error bound.

// File: rtl/gs_pkg.sv
package gs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_INIT,
      ST_RES,
      ST_UPD,
      ST_FIN
   } gs_state_t;

endpackage

// File: rtl/gs_seed_rom.sv
module gs_seed_rom #(
   parameter int SEG_BITS = 6,
   parameter int ROM_BITS = 16
) (
   input  logic [SEG_BITS:0]   idx_i,
   output logic [ROM_BITS-1:0] seed_o
);
   localparam int ENTRIES = 1 << (SEG_BITS + 1);

   initial begin
      assert (2*ROM_BITS + SEG_BITS + 4 <= 63)
         else $error("seed table arithmetic exceeds 64 bits");
      assert (SEG_BITS >= 2) else $error("SEG_BITS too small");
   end

   // Largest y with (y/2^R)^2 * m <= 1, m being the segment midpoint.
   function automatic logic [ROM_BITS-1:0] seed_of(input int idx);
      longint unsigned scale, k, m_s, lim, res, t;
      scale = 64'd1 << (SEG_BITS + 1);
      k     = longint'(idx % (1 << SEG_BITS));
      if ((idx >> SEG_BITS) != 0)
         m_s = 2*scale + 4*k + 2;
      else
         m_s = scale + 2*k + 1;
      lim = (64'd1 << (2*ROM_BITS)) * scale;
      res = 0;
      for (int b = ROM_BITS-1; b >= 0; b--) begin
         t = res | (64'd1 << b);
         if (t*t*m_s <= lim) res = t;
      end
      return res[ROM_BITS-1:0];
   endfunction

   logic [ROM_BITS-1:0] tbl [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
      assign tbl[g] = seed_of(g);
   end

   assign seed_o = tbl[idx_i];

endmodule

// File: rtl/gs_muladd.sv
module gs_muladd #(
   parameter int W   = 33,
   parameter int F   = 30,
   parameter bit SUB = 1'b0
) (
   input  logic signed [W-1:0] a_i,
   input  logic signed [W-1:0] b_i,
   input  logic signed [W-1:0] c_i,
   output logic signed [W-1:0] y_o
);
   logic signed [2*W-1:0] a_ext, b_ext, prod;
   logic signed [W-1:0]   term;

   initial begin
      assert (F < W) else $error("fraction width must be below word width");
   end

   assign a_ext = {{W{a_i[W-1]}}, a_i};
   assign b_ext = {{W{b_i[W-1]}}, b_i};
   assign prod  = a_ext * b_ext;
   assign term  = W'(prod >>> F);

   if (SUB) begin : g_sub
      assign y_o = c_i - term;
   end else begin : g_add
      assign y_o = c_i + term;
   end

endmodule

// File: rtl/gs_seq.sv
module gs_seq
   import gs_pkg::*;
#(
   parameter int ITERS = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start_i,
   output gs_state_t state_o,
   output logic      done_o
);
   localparam int IT_W = (ITERS > 1) ? $clog2(ITERS) : 1;

   initial begin
      assert (ITERS >= 1) else $error("ITERS must be at least 1");
   end

   gs_state_t       st_q;
   logic [IT_W-1:0] it_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         it_q   <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (start_i) st_q <= ST_INIT;
            ST_INIT: st_q <= ST_RES;
            ST_RES:  st_q <= ST_UPD;
            ST_UPD: begin
               if (it_q == IT_W'(ITERS-1)) begin
                  it_q <= '0;
                  st_q <= ST_FIN;
               end else begin
                  it_q <= it_q + 1'b1;
                  st_q <= ST_RES;
               end
            end
            ST_FIN: begin
               done_o <= 1'b1;
               st_q   <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign state_o = st_q;

   // R4
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R5
   init_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_INIT) |-> ($past(st_q) == ST_IDLE));

endmodule

// File: rtl/gs_sqrt_unit.sv
module gs_sqrt_unit
   import gs_pkg::*;
#(
   parameter int IN_W     = 24,
   parameter int GUARD    = 8,
   parameter int ROM_BITS = 16,
   parameter int SEG_BITS = 6,
   parameter int ITERS    = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [IN_W-1:0] value_i,
   output logic            done_o,
   output logic [IN_W-1:0] sqrt_o,
   output logic [IN_W-1:0] rsqrt_o
);
   localparam int IN_F = IN_W - 2;
   localparam int F    = IN_F + GUARD;
   localparam int W    = F + 3;
   localparam logic signed [W-1:0] HALF = W'(1) << (F - 1);

   initial begin
      assert (GUARD >= 1) else $error("GUARD must be at least 1");
      assert (F >= ROM_BITS) else $error("seed wider than working fraction");
      assert (IN_F > SEG_BITS) else $error("SEG_BITS too large for input");
   end

   gs_state_t state;
   logic      done_seq;

   gs_seq #(.ITERS(ITERS)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .state_o (state),
      .done_o  (done_seq)
   );

   // seed lookup
   logic [SEG_BITS:0]   seg_idx;
   logic [ROM_BITS-1:0] seed_raw;

   assign seg_idx = value_i[IN_W-1]
                  ? {1'b1, value_i[IN_F -: SEG_BITS]}
                  : {1'b0, value_i[IN_F-1 -: SEG_BITS]};

   gs_seed_rom #(.SEG_BITS(SEG_BITS), .ROM_BITS(ROM_BITS)) u_rom (
      .idx_i  (seg_idx),
      .seed_o (seed_raw)
   );

   logic signed [W-1:0] n_q, seed_q, x_q, h_q, r_q;
   logic signed [W-1:0] xa, xb, xc, x_next, h_next, r_next;

   assign xa = (state == ST_INIT) ? seed_q : x_q;
   assign xb = (state == ST_INIT) ? n_q    : r_q;
   assign xc = (state == ST_INIT) ? '0     : x_q;

   gs_muladd #(.W(W), .F(F), .SUB(1'b1)) u_mac_r (
      .a_i (x_q), .b_i (h_q), .c_i (HALF), .y_o (r_next)
   );

   gs_muladd #(.W(W), .F(F), .SUB(1'b0)) u_mac_x (
      .a_i (xa), .b_i (xb), .c_i (xc), .y_o (x_next)
   );

   gs_muladd #(.W(W), .F(F), .SUB(1'b0)) u_mac_h (
      .a_i (h_q), .b_i (r_q), .c_i (h_q), .y_o (h_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_q     <= '0;
         seed_q  <= '0;
         x_q     <= '0;
         h_q     <= '0;
         r_q     <= '0;
         sqrt_o  <= '0;
         rsqrt_o <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start_i) begin
                  n_q    <= $signed(W'(value_i) << GUARD);
                  seed_q <= $signed(W'(seed_raw) << (F - ROM_BITS));
               end
            end
            ST_INIT: begin
               x_q <= x_next;
               h_q <= seed_q >>> 1;
            end
            ST_RES: r_q <= r_next;
            ST_UPD: begin
               x_q <= x_next;
               h_q <= h_next;
            end
            ST_FIN: begin
               sqrt_o  <= x_q[GUARD +: IN_W];
               rsqrt_o <= h_q[GUARD-1 +: IN_W];
            end
            default: ;
         endcase
      end
   end

   assign done_o = done_seq;

   // R6
   hold_sqrt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(sqrt_o) && $stable(rsqrt_o)));

   // R2
   resid_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_UPD) |->
         ((r_q < (W'(1) <<< (F - 6))) && (r_q > -(W'(1) <<< (F - 6)))));

   // R3
   positive_est_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_UPD) |-> (!x_q[W-1] && (|x_q) && !h_q[W-1] && (|h_q)));

endmodule

// File: tb/gs_sqrt_unit_bench.sv
module gs_sqrt_unit_bench;
   localparam int ITERS = 2;
   localparam int LAT   = 2*ITERS + 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [23:0] din = 24'h400000;
   logic        done;
   logic [23:0] sq, rs;

   int  total = 0;
   int  bad = 0;
   bit  finished = 1'b0;

   always #5 clk = ~clk;

   gs_sqrt_unit #(.ITERS(ITERS)) u_gs_sqrt_unit (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .value_i (din),
      .done_o  (done),
      .sqrt_o  (sq),
      .rsqrt_o (rs)
   );

   function automatic longint unsigned isqrt(input logic [127:0] a);
      longint unsigned res, t;
      res = 0;
      for (int b = 30; b >= 0; b--) begin
         t = res | (64'd1 << b);
         if (128'(t) * 128'(t) <= a) res = t;
      end
      return res;
   endfunction

   task automatic chk(input bit ok, input string req, input longint act,
                      input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_near(input string req, input logic [23:0] act,
                           input longint unsigned exp);
      longint d;
      d = longint'(act) - longint'(exp);
      chk((d <= 4) && (d >= -4), req, longint'(act), longint'(exp));
   endtask

   task automatic run_op(input logic [23:0] v, input bit inject,
                         input string tag);
      int cnt;
      bit seen;
      longint unsigned e_sq, e_rs;
      e_sq = isqrt(128'(v) << 22);
      e_rs = isqrt((128'd1 << 66) / 128'(v));
      @(negedge clk);
      start = 1'b1;
      din   = v;
      cnt   = 0;
      seen  = 1'b0;
      while (!seen && cnt < 40) begin
         @(negedge clk);
         cnt++;
         if (inject && cnt == 2) begin
            start = 1'b1;
            din   = v ^ 24'h35A5A5;
         end else begin
            start = 1'b0;
         end
         if (done) seen = 1'b1;
      end
      // R4: done first seen LAT negedges after start
      chk(seen && cnt == LAT, "R4 latency", cnt, LAT);
      chk_near({tag, " R2 sqrt"}, sq, e_sq);
      chk_near({tag, " R3 rsqrt"}, rs, e_rs);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [23:0] keep_sq, keep_rs;
      repeat (3) @(negedge clk);
      // R1
      chk(done == 1'b0, "R1 done in reset", done, 0);
      chk(sq == 24'd0 && rs == 24'd0, "R1 outputs in reset", sq | rs, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(done == 1'b0 && sq == 24'd0, "R1 after release", sq, 0);

      // range ends
      run_op(24'h400000, 1'b0, "end");
      run_op(24'hFFFFFF, 1'b0, "end");

      // R7: first and last code of every seed segment
      for (int k = 0; k < 64; k++) begin
         run_op(24'(32'h400000 + k*32'h10000), 1'b0, "R7 lo");
         run_op(24'(32'h400000 + k*32'h10000 + 32'hFFFF), 1'b0, "R7 lo");
         run_op(24'(32'h800000 + k*32'h20000), 1'b0, "R7 hi");
         run_op(24'(32'h800000 + k*32'h20000 + 32'h1FFFF), 1'b0, "R7 hi");
      end

      // strided sweep, back to back (R8)
      for (int v = 32'h400000; v < 32'h1000000; v += 5003) begin
         run_op(24'(v), 1'b0, "R8 sweep");
      end

      // R5: stray strobe and operand change mid-operation
      run_op(24'h9C4F31, 1'b1, "R5");
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         chk(done == 1'b0, "R5 no extra done", done, 0);
      end

      // R6: outputs hold while operand moves without start
      keep_sq = sq;
      keep_rs = rs;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         din = 24'(24'h500000 + i*24'h12345);
      end
      chk(sq == keep_sq, "R6 sqrt hold", sq, keep_sq);
      chk(rs == keep_rs, "R6 rsqrt hold", rs, keep_rs);
      chk(done == 1'b0, "R6 no done", done, 0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule